// File: doc/BRIEF.md
# Fault-Hardened Synchronous FIFO

A single-clock first-in first-out buffer whose write and read pointers are each held twice: once in true form and once in inverted form. On every cycle the two copies of each pointer are compared. Any disagreement raises an error flag that stays set until the next reset. The error is intended to drive a fatal alarm elsewhere in the chip.

Both sides use a valid/ready handshake, and the block also reports its current occupancy. The read side is gated by the error flag. A pointer corrupted so that the buffer looks non-empty, or that points at a slot never written, can therefore never show up downstream as a valid beat. A parameter that is on by default forces the read data to all zeros whenever no real data is available, whether because the buffer is empty or because the error flag is set.

For one cycle after reset is released, an internal under-reset flag keeps both write-ready and read-valid low.

Top module: `hsync_fifo`

## Requirements
- R1: Straight after reset, depth is 0 and error is 0. Write-ready and read-valid are both 0 from reset release until the first rising clock edge that follows it. From that edge on, write-ready is 1 while the FIFO is not full.
- R2: Words are read out in the order they were written, and read data equals the oldest stored word while read-valid is 1.
- R3: Write-ready is 0 whenever depth equals DEPTH. A write is accepted only when write-valid and write-ready are both 1.
- R4: A cycle that has both an accepted write and an accepted read leaves the depth unchanged.
- R5: A mismatch between the true and inverted copies of either pointer sets the error output in the same cycle. The error then stays at 1 until reset.
- R6: Read-valid is 0 whenever the error output is 1, including when a corrupted pointer makes the FIFO look non-empty.
- R7: With ZERO_ON_IDLE=1, read data is all zeros whenever the FIFO is empty or the error output is 1.
- R8: The depth output equals accepted writes minus accepted reads since reset, and never exceeds DEPTH.
- R9: Read-valid is 1 exactly when the FIFO is non-empty, is past its under-reset cycle, and has no error. A read is accepted only when read-valid and read-ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wvalid_i | input | 1 | Write data offered |
| wready_o | output | 1 | FIFO can take a word |
| wdata_i | input | WIDTH | Write data |
| rvalid_o | output | 1 | Oldest word is presented |
| rready_i | input | 1 | Consumer takes the word |
| rdata_o | output | WIDTH | Read data |
| depth_o | output | $clog2(DEPTH)+1 | Number of stored words |
| err_o | output | 1 | Sticky pointer-integrity error |

## Verification
Two functions can fall in the same cycle: an accepted write and an accepted read. The bench provokes this by driving write-valid and read-ready from a pseudo-random sequence while the FIFO is partly full. It judges the result against a queue model that applies both handshakes in one step and expects the depth to hold. A second collision is a pointer fault arriving while the consumer holds read-ready high. The bench flips one bit of a pointer copy on an empty FIFO and expects, in the same cycle, the error to rise, read-valid to stay low and read data to be zero, with no read taken.

// File: rtl/hsync_fifo.sv
module hsync_fifo #(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned DEPTH        = 4,
  parameter bit          ZERO_ON_IDLE = 1'b1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wvalid_i,
  output logic                       wready_o,
  input  logic [WIDTH-1:0]           wdata_i,
  output logic                       rvalid_o,
  input  logic                       rready_i,
  output logic [WIDTH-1:0]           rdata_o,
  output logic [$clog2(DEPTH):0]     depth_o,
  output logic                       err_o
);
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned PW = AW + 1;

  logic [PW-1:0]    wptr_q, wptr_inv_q, rptr_q, rptr_inv_q;
  logic             ur_q, err_q, mismatch, empty, full, push, pop;
  logic [WIDTH-1:0] mem [DEPTH];
  logic [WIDTH-1:0] rdata_raw;

  assign mismatch = (wptr_q != ~wptr_inv_q) | (rptr_q != ~rptr_inv_q);
  assign err_o    = err_q | mismatch;

  assign empty = wptr_q == rptr_q;
  assign full  = (wptr_q[AW-1:0] == rptr_q[AW-1:0]) && (wptr_q[AW] != rptr_q[AW]);

  assign wready_o = ~full & ~ur_q;
  assign rvalid_o = ~empty & ~ur_q & ~err_o;
  assign push     = wvalid_i & wready_o;
  assign pop      = rvalid_o & rready_i;
  assign depth_o  = wptr_q - rptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ur_q       <= 1'b1;
      err_q      <= 1'b0;
      wptr_q     <= '0;
      wptr_inv_q <= '1;
      rptr_q     <= '0;
      rptr_inv_q <= '1;
    end else begin
      ur_q  <= 1'b0;
      err_q <= err_q | mismatch;
      if (push) begin
        wptr_q     <= wptr_q + 1'b1;
        wptr_inv_q <= ~(wptr_q + 1'b1);
      end
      if (pop) begin
        rptr_q     <= rptr_q + 1'b1;
        rptr_inv_q <= ~(rptr_q + 1'b1);
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (push) mem[wptr_q[AW-1:0]] <= wdata_i;
  end

  assign rdata_raw = mem[rptr_q[AW-1:0]];

  generate
    if (ZERO_ON_IDLE) begin : g_zero
      assign rdata_o = (empty | err_o) ? '0 : rdata_raw;
    end else begin : g_raw
      assign rdata_o = rdata_raw;
    end
  endgenerate
endmodule

module hsync_fifo_chk #(
  parameter int unsigned WIDTH        = 8,
  parameter int unsigned DEPTH        = 4,
  parameter bit          ZERO_ON_IDLE = 1'b1
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wvalid_i,
  input logic                   wready_o,
  input logic                   rvalid_o,
  input logic                   rready_i,
  input logic [WIDTH-1:0]       rdata_o,
  input logic [$clog2(DEPTH):0] depth_o,
  input logic                   err_o
);
  assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DEPTH);
  assert_full_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == DEPTH) |-> !wready_o);
  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_err_kills_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !rvalid_o);
  assert_empty_no_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (depth_o == 0) |-> !rvalid_o);
  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ZERO_ON_IDLE && !rvalid_o && (err_o || depth_o == 0)) |-> rdata_o == '0);
  assert_both_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_o && wvalid_i && wready_o && rvalid_o && rready_i) |=> (err_o || depth_o == $past(depth_o)));
endmodule

bind hsync_fifo hsync_fifo_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH), .ZERO_ON_IDLE(ZERO_ON_IDLE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wvalid_i(wvalid_i), .wready_o(wready_o),
  .rvalid_o(rvalid_o), .rready_i(rready_i), .rdata_o(rdata_o),
  .depth_o(depth_o), .err_o(err_o)
);

// File: tb/hsync_fifo_tb.sv
module hsync_fifo_tb;
  localparam int W = 8;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wvalid = 1'b0, rready = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         wready, rvalid, err;
  logic [W-1:0] rdata;
  logic [$clog2(D):0] depth;

  int tests = 0, fails = 0;
  logic [W-1:0] q[$];
  bit   ur_m = 1'b1;
  int   pushes = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hsync_fifo #(.WIDTH(W), .DEPTH(D), .ZERO_ON_IDLE(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wvalid_i(wvalid), .wready_o(wready),
    .wdata_i(wdata), .rvalid_o(rvalid), .rready_i(rready), .rdata_o(rdata),
    .depth_o(depth), .err_o(err)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic compare_all(input bit first);
    bit ew, ev;
    ew = !ur_m && q.size() < D;
    ev = !ur_m && q.size() > 0;
    if (first) begin
      chk("R1", "wready in under-reset cycle", int'(wready), 0);
      chk("R1", "rvalid in under-reset cycle", int'(rvalid), 0);
      chk("R1", "depth after reset", int'(depth), 0);
      chk("R1", "err after reset", int'(err), 0);
    end else begin
      chk("R3", "wready", int'(wready), int'(ew));
      chk("R9", "rvalid", int'(rvalid), int'(ev));
      chk("R8", "depth", int'(depth), q.size());
      chk("R5", "err", int'(err), 0);
      if (ev) chk("R2", "rdata order", int'(rdata), int'(q[0]));
      else    chk("R7", "rdata zero when empty", int'(rdata), 0);
    end
  endtask

  task automatic step_model();
    bit pu, po;
    pu = wvalid && !ur_m && q.size() < D;
    po = rready && !ur_m && q.size() > 0;
    if (pu && po) begin
      // R4: both handshakes in one cycle, depth must hold
      q.push_back(wdata);
      void'(q.pop_front());
    end else if (pu) q.push_back(wdata);
    else if (po) void'(q.pop_front());
    if (pu) pushes++;
    ur_m = 1'b0;
  endtask

  initial begin
    int cyc = 20000;
    while (cyc > 0 && !done) begin
      @(posedge clk);
      cyc--;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ctr = 8'h10;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare_all(1'b1);
    wvalid = 1'b1; wdata = ctr;
    step_model();
    for (int c = 0; c < 260; c++) begin
      @(negedge clk);
      compare_all(1'b0);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ctr = ctr + 8'd7;
      wdata = ctr;
      if (c < 12)       begin wvalid = 1'b1; rready = 1'b0; end
      else if (c < 24)  begin wvalid = 1'b0; rready = 1'b1; end
      else if (c < 244) begin wvalid = lfsr[0] | lfsr[3]; rready = lfsr[1] | lfsr[5]; end
      else              begin wvalid = 1'b0; rready = 1'b1; end
      step_model();
    end
    @(negedge clk);
    compare_all(1'b0);
    chk("R8", "empty before fault", int'(depth), 0);
    // flip one bit of the true write-pointer copy on an empty FIFO
    wvalid = 1'b0; rready = 1'b1;
    force u_dut.wptr_q = 3'((pushes % (2 * D)) ^ 1);
    #1 release u_dut.wptr_q;
    #1;
    chk("R5", "err on pointer mismatch", int'(err), 1);
    chk("R6", "rvalid blocked by err", int'(rvalid), 0);
    chk("R7", "rdata zero on err", int'(rdata), 0);
    @(negedge clk);
    chk("R5", "err sticky", int'(err), 1);
    chk("R6", "rvalid still blocked", int'(rvalid), 0);
    chk("R7", "rdata still zero", int'(rdata), 0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule